// File: doc/BRIEF.md
# Plateau-Sampled Overvoltage Fault Latch

This block watches the gate-drive bit of a flyback switching controller and samples an overvoltage comparator flag once per switching cycle, a fixed delay after the gate turns off. At that point the auxiliary winding has settled onto its plateau and the leakage ringing has died out. One sampled high sets a fault bit. The fault bit stays set until the supply collapses far enough to raise the deep-reset flag, or until power-on reset. The switching supervisor reads the fault bit and stops all switching while it is set. An external source, such as a temperature sensor, can force the comparator flag high and trips the latch in the same way.

Two delay variants exist. The standard delay is 450 clock cycles, which is 4.5 us at 100 MHz. The fast delay is 150 clock cycles, which is 1.5 us. The variant is chosen by a select input and captured at each turn-off. The counter only runs while the gate stays low. A turn-on before the delay expires drops the pending sample.

Top module: `ov_plateau_latch`

## Requirements
- R1: While `rstN` is low and right after it is released, `faultLatched` and `sampleStrobe` are 0.
- R2: With `fastSel` = 0 on the first low cycle after a turn-off, `sampleStrobe` is high for the cycle after the 450th consecutive clock edge that sees `gateOn` low. A turn-off is an edge seeing `gateOn` low after an edge seeing it high.
- R3: With `fastSel` = 1 on that first low cycle, the same happens after the 150th low edge. Changes of `fastSel` later in the run have no effect.
- R4: If `gateOn` returns high before the delay is complete, no sample is taken for that turn-off. After reset or deep reset with the gate low, no sample is taken until a new high-to-low transition.
- R5: If `ovFlag` is 1 on the sampling edge, `faultLatched` becomes 1 in the same cycle as `sampleStrobe`.
- R6: `ovFlag` on any edge other than a sampling edge has no effect on `faultLatched`.
- R7: Once set, `faultLatched` stays 1 regardless of `gateOn`, `ovFlag` and `fastSel`, until `deepReset` or `rstN`.
- R8: `deepReset` = 1 on an edge clears `faultLatched` one cycle later and cancels any pending sample. It takes priority over a sample on the same edge, so no strobe and no set occur.
- R9: `sampleStrobe` is a single-cycle pulse, at most one per turn-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (100 MHz nominal) |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| gateOn | input | 1 | Gate-drive state, 1 = switch conducting |
| ovFlag | input | 1 | Overvoltage comparator output, 1 = above threshold |
| fastSel | input | 1 | Delay variant: 0 = standard, 1 = fast |
| deepReset | input | 1 | Supply below deep-reset level; clears the fault |
| faultLatched | output | 1 | Latched overvoltage fault |
| sampleStrobe | output | 1 | One-cycle pulse marking each plateau sample |

## Verification
The sampling edge is the N-th consecutive clock edge that sees the gate low, where N is 450 or 150. Both `sampleStrobe` and a newly set `faultLatched` are due in the cycle after that edge. A deep-reset clear is likewise due one cycle after the edge that sees `deepReset`. The bench drives inputs on falling edges and keeps a cycle-level reference model updated on rising edges. It compares both outputs against the model in the middle of every cycle. Because the comparison runs every cycle, a strobe that comes one cycle early or late, or a stray fault set, is caught at the exact cycle it appears.

// File: rtl/ovlatch_pkg.sv
package ovlatch_pkg;
  // Strobes issued by the control part to the datapath each cycle.
  typedef struct packed {
    logic load;     // first low cycle after turn-off: start delay count
    logic advance;  // gate still low, delay not yet complete
    logic sample;   // delay complete on this edge: take the plateau sample
  } ovlStrobe_t;
endpackage

// File: rtl/ovlatch_ctrl.sv
module ovlatch_ctrl
  import ovlatch_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       gateOn,
  input  logic       deepReset,
  input  logic       cntDone,
  output ovlStrobe_t strobes
);
  logic gatePrev;
  logic pending;
  logic turnOff;

  assign turnOff = gatePrev & ~gateOn;

  always_comb begin
    strobes.load    = turnOff & ~deepReset;
    strobes.sample  = pending & ~gateOn & cntDone & ~deepReset;
    strobes.advance = pending & ~gateOn & ~cntDone & ~deepReset;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gatePrev <= 1'b0;
      pending  <= 1'b0;
    end else begin
      gatePrev <= gateOn;
      if (deepReset)
        pending <= 1'b0;
      else if (strobes.load)
        pending <= 1'b1;
      else if (pending && (gateOn || cntDone))
        pending <= 1'b0;
    end
  end

  // R4: a turn-on drops the pending sample, so no sample on the following edge
  assert_cancel_R4: assert property (@(posedge clk) disable iff (!rstN)
    gateOn |=> !strobes.sample);

  // R8: deep reset cancels any pending sample
  assert_deep_cancel_R8: assert property (@(posedge clk) disable iff (!rstN)
    deepReset |=> !strobes.sample);
endmodule

// File: rtl/ovlatch_dp.sv
module ovlatch_dp
  import ovlatch_pkg::*;
#(
  parameter int STD_DELAY_CYC  = 450,
  parameter int FAST_DELAY_CYC = 150
) (
  input  logic       clk,
  input  logic       rstN,
  input  ovlStrobe_t strobes,
  input  logic       fastSel,
  input  logic       ovFlag,
  input  logic       deepReset,
  output logic       cntDone,
  output logic       sampleStrobe,
  output logic       faultLatched
);
  localparam int MAX_DELAY = (STD_DELAY_CYC > FAST_DELAY_CYC) ? STD_DELAY_CYC : FAST_DELAY_CYC;
  localparam int CNT_W     = $clog2(MAX_DELAY + 1);
  localparam logic [CNT_W-1:0] STD_LAST  = CNT_W'(STD_DELAY_CYC - 1);
  localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_DELAY_CYC - 1);

  logic [CNT_W-1:0] lowCnt;
  logic [CNT_W-1:0] lastCnt;

  assign cntDone = (lowCnt == lastCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt  <= '0;
      lastCnt <= STD_LAST;
    end else if (strobes.load) begin
      lowCnt  <= CNT_W'(1);
      lastCnt <= fastSel ? FAST_LAST : STD_LAST;
    end else if (strobes.advance) begin
      lowCnt  <= lowCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleStrobe <= 1'b0;
      faultLatched <= 1'b0;
    end else begin
      sampleStrobe <= strobes.sample;
      if (deepReset)
        faultLatched <= 1'b0;
      else if (strobes.sample && ovFlag)
        faultLatched <= 1'b1;
    end
  end

  // R5: overvoltage seen on the sampling edge sets the fault with the strobe
  assert_set_on_sample_R5: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStrobe && $past(ovFlag)) |-> faultLatched);

  // R6: the fault only rises together with a sample strobe
  assert_rise_needs_sample_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultLatched) |-> sampleStrobe);

  // R7: fault is held unless deep reset is seen
  assert_fault_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (faultLatched && !deepReset) |=> faultLatched);

  // R8: deep reset clears the fault on the next cycle
  assert_deep_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    deepReset |=> !faultLatched);

  // R9: strobe lasts one cycle
  assert_strobe_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |=> !sampleStrobe);
endmodule

// File: rtl/ov_plateau_latch.sv
module ov_plateau_latch
  import ovlatch_pkg::*;
#(
  parameter int STD_DELAY_CYC  = 450,
  parameter int FAST_DELAY_CYC = 150
) (
  input  logic clk,
  input  logic rstN,
  input  logic gateOn,
  input  logic ovFlag,
  input  logic fastSel,
  input  logic deepReset,
  output logic faultLatched,
  output logic sampleStrobe
);
  ovlStrobe_t strobes;
  logic       cntDone;

  ovlatch_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .gateOn    (gateOn),
    .deepReset (deepReset),
    .cntDone   (cntDone),
    .strobes   (strobes)
  );

  ovlatch_dp #(
    .STD_DELAY_CYC  (STD_DELAY_CYC),
    .FAST_DELAY_CYC (FAST_DELAY_CYC)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .fastSel      (fastSel),
    .ovFlag       (ovFlag),
    .deepReset    (deepReset),
    .cntDone      (cntDone),
    .sampleStrobe (sampleStrobe),
    .faultLatched (faultLatched)
  );
endmodule

// File: tb/ov_plateau_latch_tb.sv
module ov_plateau_latch_tb;
  localparam int STD_D  = 450;
  localparam int FAST_D = 150;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic gateOn = 1'b0, ovFlag = 1'b0, fastSel = 1'b0, deepReset = 1'b0;
  logic faultLatched, sampleStrobe;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit finished = 0;
  string curTag = "R1";

  // reference model state
  bit mHigh = 0;
  int mRun = 0;
  int mLim = STD_D;
  bit mFault = 0;
  bit mStrobe = 0;

  always #5 clk = ~clk;

  ov_plateau_latch #(.STD_DELAY_CYC(STD_D), .FAST_DELAY_CYC(FAST_D)) u_dut (
    .clk(clk), .rstN(rstN), .gateOn(gateOn), .ovFlag(ovFlag), .fastSel(fastSel),
    .deepReset(deepReset), .faultLatched(faultLatched), .sampleStrobe(sampleStrobe)
  );

  function automatic int limitFor(bit fast);
    return fast ? FAST_D : STD_D;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mHigh = 0; mRun = 0; mFault = 0; mStrobe = 0;
    end else begin
      mStrobe = 0;
      if (deepReset) begin
        mFault = 0; mHigh = gateOn; mRun = 0;
      end else if (gateOn) begin
        mHigh = 1; mRun = 0;
      end else if (mHigh) begin
        mRun++;
        if (mRun == 1) mLim = limitFor(fastSel);
        if (mRun == mLim) begin
          mStrobe = 1;
          if (ovFlag) mFault = 1;
        end
      end
    end
  end

  task automatic check(string tag, logic act, logic exp, string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", tag, what, cycles, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    check(curTag, sampleStrobe, mStrobe, "sampleStrobe");
    check(curTag, faultLatched, mFault, "faultLatched");
  endtask

  task automatic gateHigh(int n);
    gateOn = 1; ovFlag = 0; deepReset = 0;
    for (int i = 0; i < n; i++) step();
  endtask

  // ovMode: 0 none, 1 only at ovAt, 2 everywhere except ovAt
  task automatic gateLow(int n, bit fast, int ovMode, int ovAt, int drAt);
    gateOn = 0;
    for (int i = 1; i <= n; i++) begin
      fastSel = (i == 1) ? fast : ~fast;
      ovFlag = (ovMode == 1) ? (i == ovAt) : (ovMode == 2) ? (i != ovAt) : 1'b0;
      deepReset = (i == drAt);
      step();
    end
    ovFlag = 0; deepReset = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      mismatched++;
      compared++;
      $display("FAIL watchdog expired at cycle %0d: actual running expected done", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h1d3c;
    void'($urandom(seed));
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", faultLatched, 1'b0, "fault in reset");
    check("R1", sampleStrobe, 1'b0, "strobe in reset");
    rstN = 1;
    curTag = "R1"; step();
    check("R1", faultLatched, 1'b0, "fault after reset");
    // R4: gate low out of reset must not sample
    curTag = "R4"; gateLow(500, 0, 1, STD_D, 0);
    // R2: standard delay
    curTag = "R2"; gateHigh(3); gateLow(460, 0, 0, 0, 0);
    // R3: fast delay, fastSel flips after first low cycle
    curTag = "R3"; gateHigh(2); gateLow(160, 1, 0, 0, 0);
    // R4: early turn-on cancels
    curTag = "R4"; gateHigh(2); gateLow(STD_D - 1, 0, 1, STD_D - 1, 0);
    gateHigh(1); gateLow(FAST_D - 1, 1, 0, 0, 0);
    // R6: overvoltage everywhere except the sampling edge
    curTag = "R6"; gateHigh(2); gateLow(470, 0, 2, STD_D, 0);
    check("R6", faultLatched, 1'b0, "fault after off-sample ov");
    // R5: overvoltage exactly on sampling edge
    curTag = "R5"; gateHigh(2); gateLow(200, 1, 1, FAST_D, 0);
    check("R5", faultLatched, 1'b1, "fault after sampled ov");
    // R7: stays set through activity
    curTag = "R7";
    for (int k = 0; k < 3; k++) begin gateHigh(4); gateLow(300, k[0], 0, 0, 0); end
    check("R7", faultLatched, 1'b1, "fault held");
    // R8: deep reset clears, cancels pending, wins over simultaneous set
    curTag = "R8"; gateHigh(2); gateLow(5, 0, 0, 0, 3);
    check("R8", faultLatched, 1'b0, "fault after deep reset");
    gateHigh(2); gateLow(STD_D + 10, 0, 2, 0, 100);
    gateHigh(2); gateLow(FAST_D + 10, 1, 1, FAST_D, FAST_D);
    check("R8", faultLatched, 1'b0, "deep reset priority");
    // R9 and all: constrained random
    curTag = "R9";
    for (int p = 0; p < 40; p++) begin
      int len, mode, drAt;
      bit fast;
      gateHigh(1 + ($urandom % 5));
      fast = $urandom % 2;
      len = 100 + ($urandom % 420);
      mode = $urandom % 3;
      drAt = (($urandom % 4) == 0) ? 1 + ($urandom % len) : 0;
      gateLow(len, fast, mode, limitFor(fast), drAt);
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule